// File: doc/BRIEF.md
# RV32E Register-Range Legality Checker

This block sits next to an RV32I instruction decoder and decides, in the same cycle the instruction word arrives, whether the instruction names a register that a 16-entry register file does not have. It looks at the major opcode, and for system instructions at funct3, to work out which of the three register fields the instruction actually reads or writes. The usage comes from the instruction format alone, never from how the ALU operands are selected. A store, for example, feeds an immediate to the ALU but still reads its data register, so that register is range-checked.

When reduced-register mode is enabled and the word is valid, the illegal-register flag goes high if any used field holds an index of 16 or more. Bits in field positions that a format does not use as registers are ignored. The per-field usage flags are also driven out for debug. They are pure decode and do not depend on the valid or mode inputs.

Top module: `rv32e_regrange_check`

## Requirements
- R1: With `rv32e_en_i` and `valid_i` both high, `illegal_reg_o` is high exactly when some used field has bit 4 set. The fields are rd at bits 11:7, rs1 at bits 19:15 and rs2 at bits 24:20.
- R2: A store (opcode 0100011) uses rs1 and rs2 and no rd. An rs2 of 16 or more raises the flag even when rs1 is low.
- R3: A branch (opcode 1100011) uses rs1 and rs2 and no rd. Either field being high raises the flag.
- R4: LUI (0110111), AUIPC (0010111) and JAL (1101111) use rd only. High values in bits 24:15 never raise the flag.
- R5: JALR (1100111), loads (0000011) and OP-IMM (0010011) use rs1 and rd. Bits 24:20 never raise the flag.
- R6: OP (0110011) uses rs1, rs2 and rd.
- R7: SYSTEM (1110011) with funct3 (bits 14:12) in 001 to 011 uses rs1 and rd. With funct3 in 101 to 111 it uses rd only. With funct3 000 it uses nothing. MISC-MEM (0001111) and any other opcode use nothing.
- R8: With `rv32e_en_i` low or `valid_i` low, `illegal_reg_o` is low for every instruction word.
- R9: Used indices 0 to 15 never raise the flag, and 16 does.
- R10: All outputs follow the inputs combinationally, with no clocked state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr_i | input | 32 | Instruction word |
| valid_i | input | 1 | Instruction word is valid |
| rv32e_en_i | input | 1 | Reduced 16-register mode enable |
| illegal_reg_o | output | 1 | A used register index is out of range |
| use_rs1_o | output | 1 | Instruction reads rs1 |
| use_rs2_o | output | 1 | Instruction reads rs2 |
| use_rd_o | output | 1 | Instruction writes rd |

## Verification
The hardest case is a word whose only high register sits in a field the ALU does not route: a store with a low base and rs2 of 16 or more. A checker that keyed on operand selects would pass it. The stimulus builds such stores and branches, and it also builds I-type and U-type words whose immediate bits fill the rs2 or rs1 positions with ones, so that a wrong usage decode shows up as a flag in one direction or the other. Each opcode is driven at the 15/16 index boundary, and mode and valid are toggled on a word that would otherwise be illegal.

// File: rtl/rv32e_chk_pkg.sv
// Package: opcode constants, field positions and the usage record shared by
// the register-range checker. Assumes the standard 32-bit base encoding.
package rv32e_chk_pkg;
    localparam int unsigned INSN_W    = 32;
    localparam int unsigned OPC_W     = 7;
    localparam int unsigned REG_IDX_W = 5;
    localparam int unsigned F3_W      = 3;
    localparam int unsigned NUM_FLD   = 3;

    // Low bit of each register field inside the word
    localparam int unsigned RD_LSB  = 7;
    localparam int unsigned RS1_LSB = 15;
    localparam int unsigned RS2_LSB = 20;
    localparam int unsigned F3_LSB  = 12;

    localparam logic [OPC_W-1:0] OPC_LUI    = 7'b0110111;
    localparam logic [OPC_W-1:0] OPC_AUIPC  = 7'b0010111;
    localparam logic [OPC_W-1:0] OPC_JAL    = 7'b1101111;
    localparam logic [OPC_W-1:0] OPC_JALR   = 7'b1100111;
    localparam logic [OPC_W-1:0] OPC_BRANCH = 7'b1100011;
    localparam logic [OPC_W-1:0] OPC_LOAD   = 7'b0000011;
    localparam logic [OPC_W-1:0] OPC_STORE  = 7'b0100011;
    localparam logic [OPC_W-1:0] OPC_OPIMM  = 7'b0010011;
    localparam logic [OPC_W-1:0] OPC_OP     = 7'b0110011;
    localparam logic [OPC_W-1:0] OPC_FENCE  = 7'b0001111;
    localparam logic [OPC_W-1:0] OPC_SYSTEM = 7'b1110011;

    typedef struct packed {
        logic rs1;
        logic rs2;
        logic rd;
    } reg_use_t;
endpackage

// File: rtl/rv_reg_usage_dec.sv
// Module: rv_reg_usage_dec
// Derives which register fields an instruction touches from its major opcode
// and, for system instructions, from funct3. Operand-select encodings of any
// downstream ALU are deliberately not consulted. Purely combinational.
module rv_reg_usage_dec
    import rv32e_chk_pkg::*;
(
    input  logic [OPC_W-1:0] opcode_i,
    input  logic [F3_W-1:0]  funct3_i,
    output reg_use_t         use_o
);
    // Format-based usage lookup
    always_comb begin
        use_o = '{rs1: 1'b0, rs2: 1'b0, rd: 1'b0};
        unique case (opcode_i)
            OPC_LUI, OPC_AUIPC, OPC_JAL:
                use_o = '{rs1: 1'b0, rs2: 1'b0, rd: 1'b1};
            OPC_JALR, OPC_LOAD, OPC_OPIMM:
                use_o = '{rs1: 1'b1, rs2: 1'b0, rd: 1'b1};
            OPC_OP:
                use_o = '{rs1: 1'b1, rs2: 1'b1, rd: 1'b1};
            OPC_STORE, OPC_BRANCH:
                use_o = '{rs1: 1'b1, rs2: 1'b1, rd: 1'b0};
            OPC_SYSTEM: begin
                if (funct3_i[1:0] != 2'b00) begin
                    use_o.rd  = 1'b1;
                    use_o.rs1 = ~funct3_i[2];
                end
            end
            default: use_o = '{rs1: 1'b0, rs2: 1'b0, rd: 1'b0};
        endcase
    end
endmodule

// File: rtl/rv_idx_range.sv
// Module: rv_idx_range
// Flags a register index that lies outside a register file of 2**LIM_W
// entries. Assumes IDX_W > LIM_W. Purely combinational.
module rv_idx_range #(
    parameter int unsigned IDX_W = 5,
    parameter int unsigned LIM_W = 4
) (
    input  logic [IDX_W-1:0] idx_i,
    output logic             over_o
);
    localparam int unsigned HI_W = IDX_W - LIM_W;

    logic [HI_W-1:0] hi_bits;

    // Any bit at or above the limit position puts the index out of range
    always_comb begin
        hi_bits = idx_i[IDX_W-1:LIM_W];
        over_o  = |hi_bits;
    end
endmodule

// File: rtl/rv32e_regrange_check.sv
// Module: rv32e_regrange_check (top)
// Combinational legality check for reduced register mode: raises
// illegal_reg_o when a field that the instruction really uses names a
// register beyond the 16-entry file. Assumes a 32-bit base encoding; no
// clock or reset, outputs are valid in the cycle of the input word.
module rv32e_regrange_check
    import rv32e_chk_pkg::*;
#(
    parameter int unsigned E_REG_BITS = 4
) (
    input  logic [INSN_W-1:0] instr_i,
    input  logic              valid_i,
    input  logic              rv32e_en_i,
    output logic              illegal_reg_o,
    output logic              use_rs1_o,
    output logic              use_rs2_o,
    output logic              use_rd_o
);
    localparam int unsigned FLD_RD  = 0;
    localparam int unsigned FLD_RS1 = 1;
    localparam int unsigned FLD_RS2 = 2;
    localparam int unsigned FLD_LSB [NUM_FLD] = '{RD_LSB, RS1_LSB, RS2_LSB};

    reg_use_t             reg_use;
    logic [NUM_FLD-1:0]   fld_used;
    logic [NUM_FLD-1:0]   fld_over;
    logic [6:0]           unused_imm_hi;

    // Sinks upper bits that never name a register
    assign unused_imm_hi = instr_i[31:25];

    rv_reg_usage_dec u_usage (
        .opcode_i (instr_i[OPC_W-1:0]),
        .funct3_i (instr_i[F3_LSB +: F3_W]),
        .use_o    (reg_use)
    );

    // One range comparator per register field
    for (genvar g = 0; g < NUM_FLD; g++) begin : g_fld
        rv_idx_range #(
            .IDX_W (REG_IDX_W),
            .LIM_W (E_REG_BITS)
        ) u_rng (
            .idx_i  (instr_i[FLD_LSB[g] +: REG_IDX_W]),
            .over_o (fld_over[g])
        );
    end

    // Map usage record onto field order
    always_comb begin
        fld_used          = '0;
        fld_used[FLD_RD]  = reg_use.rd;
        fld_used[FLD_RS1] = reg_use.rs1;
        fld_used[FLD_RS2] = reg_use.rs2;
    end

    // Combine usage, range result, mode and valid
    always_comb begin
        illegal_reg_o = rv32e_en_i & valid_i & |(fld_used & fld_over);
        use_rs1_o     = reg_use.rs1;
        use_rs2_o     = reg_use.rs2;
        use_rd_o      = reg_use.rd;
    end
endmodule

// File: rtl/rv32e_regrange_sva.sv
// Module: rv32e_regrange_sva
// Immediate-assertion checker bound to the top; the block has no clock, so
// each property is evaluated whenever its inputs settle.
module rv32e_regrange_sva
    import rv32e_chk_pkg::*;
(
    input logic [OPC_W-1:0] opcode_i,
    input logic             rd_hi_i,
    input logic             rs1_hi_i,
    input logic             rs2_hi_i,
    input logic             valid_i,
    input logic             rv32e_en_i,
    input logic             illegal_reg_o,
    input logic             use_rs1_o,
    input logic             use_rs2_o,
    input logic             use_rd_o
);
    // Property evaluation on every input change
    always_comb begin
        if (!(rv32e_en_i && valid_i))
            AST_OFF_NO_FLAG: assert (!illegal_reg_o);                      // R8
        if (opcode_i == OPC_STORE)
            AST_STORE_RS2_USED: assert (use_rs2_o && use_rs1_o && !use_rd_o); // R2
        if (opcode_i == OPC_BRANCH)
            AST_BRANCH_BOTH_SRC: assert (use_rs1_o && use_rs2_o && !use_rd_o); // R3
        if (opcode_i == OPC_LUI || opcode_i == OPC_AUIPC || opcode_i == OPC_JAL)
            AST_UPPER_RD_ONLY: assert (use_rd_o && !use_rs1_o && !use_rs2_o); // R4
        if (illegal_reg_o)
            AST_FLAG_HAS_CAUSE: assert ((use_rd_o && rd_hi_i) || (use_rs1_o && rs1_hi_i)
                                        || (use_rs2_o && rs2_hi_i));       // R1
        if (!rd_hi_i && !rs1_hi_i && !rs2_hi_i)
            AST_LOW_IDX_CLEAN: assert (!illegal_reg_o);                    // R9
    end
endmodule

bind rv32e_regrange_check rv32e_regrange_sva u_sva (
    .opcode_i      (instr_i[6:0]),
    .rd_hi_i       (instr_i[11]),
    .rs1_hi_i      (instr_i[19]),
    .rs2_hi_i      (instr_i[24]),
    .valid_i       (valid_i),
    .rv32e_en_i    (rv32e_en_i),
    .illegal_reg_o (illegal_reg_o),
    .use_rs1_o     (use_rs1_o),
    .use_rs2_o     (use_rs2_o),
    .use_rd_o      (use_rd_o)
);

// File: tb/rv32e_regrange_check_bench.sv
module rv32e_regrange_check_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] instr = '0;
    logic        valid = 1'b0;
    logic        en = 1'b0;
    logic        ill, u1, u2, ud;
    int          n_run = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    always #4 clk = ~clk;

    rv32e_regrange_check u_rv32e_regrange_check (
        .instr_i (instr), .valid_i (valid), .rv32e_en_i (en),
        .illegal_reg_o (ill), .use_rs1_o (u1), .use_rs2_o (u2), .use_rd_o (ud)
    );

    function automatic logic [31:0] mk(input logic [6:0] opc, input logic [2:0] f3,
                                       input logic [4:0] rd, input logic [4:0] rs1,
                                       input logic [4:0] rs2, input logic [6:0] hi);
        return {hi, rs2, rs1, f3, rd, opc};
    endfunction

    // Drive a word away from the clock edge and compare all outputs
    task automatic apply(input string req, input logic [31:0] w, input logic v, input logic e,
                         input logic x_ill, input logic x1, input logic x2, input logic xd);
        @(negedge clk);
        instr = w; valid = v; en = e;
        #1;
        n_run++;
        if ({ill, u1, u2, ud} !== {x_ill, x1, x2, xd}) begin
            n_fail++;
            $display("FAIL %s word=%h ill/rs1/rs2/rd actual=%b%b%b%b expected=%b%b%b%b",
                     req, w, ill, u1, u2, ud, x_ill, x1, x2, xd);
        end
    endtask

    task automatic t_reset;
        apply("R8 reset", 32'h0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_store;   // R2: high data register behind an immediate operand
        apply("R2 store low",  mk(7'b0100011, 3'd2, 5'd31, 5'd10, 5'd15, 7'h7f), 1, 1, 0, 1, 1, 0);
        apply("R2 store rs2",  mk(7'b0100011, 3'd2, 5'd0,  5'd10, 5'd31, 7'h00), 1, 1, 1, 1, 1, 0);
        apply("R2 store rs1",  mk(7'b0100011, 3'd0, 5'd0,  5'd16, 5'd1,  7'h00), 1, 1, 1, 1, 1, 0);
    endtask

    task automatic t_branch;  // R3
        apply("R3 branch low", mk(7'b1100011, 3'd1, 5'd31, 5'd3, 5'd4, 7'h00), 1, 1, 0, 1, 1, 0);
        apply("R3 branch rs2", mk(7'b1100011, 3'd0, 5'd0,  5'd3, 5'd20, 7'h00), 1, 1, 1, 1, 1, 0);
        apply("R3 branch rs1", mk(7'b1100011, 3'd4, 5'd0,  5'd17, 5'd2, 7'h00), 1, 1, 1, 1, 1, 0);
    endtask

    task automatic t_upper;   // R4: immediate ones in rs positions ignored
        apply("R4 lui imm",   mk(7'b0110111, 3'd7, 5'd5,  5'd31, 5'd31, 7'h7f), 1, 1, 0, 0, 0, 1);
        apply("R4 auipc rd",  mk(7'b0010111, 3'd0, 5'd16, 5'd0,  5'd0,  7'h00), 1, 1, 1, 0, 0, 1);
        apply("R4 jal imm",   mk(7'b1101111, 3'd7, 5'd1,  5'd31, 5'd31, 7'h7f), 1, 1, 0, 0, 0, 1);
    endtask

    task automatic t_itype;   // R5: bits 24:20 are immediate
        apply("R5 opimm imm", mk(7'b0010011, 3'd0, 5'd2, 5'd3, 5'd31, 7'h7f), 1, 1, 0, 1, 0, 1);
        apply("R5 load rs1",  mk(7'b0000011, 3'd2, 5'd2, 5'd24, 5'd0, 7'h00), 1, 1, 1, 1, 0, 1);
        apply("R5 jalr rd",   mk(7'b1100111, 3'd0, 5'd30, 5'd1, 5'd16, 7'h00), 1, 1, 1, 1, 0, 1);
    endtask

    task automatic t_op;      // R6
        apply("R6 op low", mk(7'b0110011, 3'd0, 5'd15, 5'd15, 5'd15, 7'h20), 1, 1, 0, 1, 1, 1);
        apply("R6 op rs2", mk(7'b0110011, 3'd0, 5'd1, 5'd2, 5'd18, 7'h00), 1, 1, 1, 1, 1, 1);
        apply("R6 op rd",  mk(7'b0110011, 3'd7, 5'd19, 5'd2, 5'd3, 7'h00), 1, 1, 1, 1, 1, 1);
    endtask

    task automatic t_system;  // R7
        apply("R7 csrrw rs1",  mk(7'b1110011, 3'd1, 5'd1, 5'd20, 5'd31, 7'h7f), 1, 1, 1, 1, 0, 1);
        apply("R7 csrrwi uimm", mk(7'b1110011, 3'd5, 5'd1, 5'd20, 5'd31, 7'h7f), 1, 1, 0, 0, 0, 1);
        apply("R7 csrrci rd",  mk(7'b1110011, 3'd7, 5'd25, 5'd0, 5'd0, 7'h00), 1, 1, 1, 0, 0, 1);
        apply("R7 ecall",      mk(7'b1110011, 3'd0, 5'd31, 5'd31, 5'd31, 7'h7f), 1, 1, 0, 0, 0, 0);
        apply("R7 fence",      mk(7'b0001111, 3'd0, 5'd31, 5'd31, 5'd31, 7'h7f), 1, 1, 0, 0, 0, 0);
        apply("R7 unknown",    mk(7'b1111111, 3'd0, 5'd31, 5'd31, 5'd31, 7'h7f), 1, 1, 0, 0, 0, 0);
    endtask

    task automatic t_gating;  // R8: usage still decoded, flag held low
        logic [31:0] w;
        w = mk(7'b0110011, 3'd0, 5'd31, 5'd31, 5'd31, 7'h00);
        apply("R8 mode off",  w, 1, 0, 0, 1, 1, 1);
        apply("R8 not valid", w, 0, 1, 0, 1, 1, 1);
        apply("R8 both on",   w, 1, 1, 1, 1, 1, 1);
    endtask

    task automatic t_boundary; // R9, R1: sweep every index on the rd of OP
        for (int i = 0; i < 32; i++) begin
            apply(i < 16 ? "R9 rd low" : "R1 rd high",
                  mk(7'b0110011, 3'd0, i[4:0], 5'd0, 5'd0, 7'h00), 1, 1, (i >= 16), 1, 1, 1);
        end
    endtask

    task automatic t_comb;    // R10: output follows input without a clock edge
        @(negedge clk);
        instr = mk(7'b0100011, 3'd2, 5'd0, 5'd1, 5'd16, 7'h00); valid = 1; en = 1;
        #1; n_run++;
        if (ill !== 1'b1) begin n_fail++; $display("FAIL R10 rise actual=%b expected=1", ill); end
        instr[24] = 1'b0;
        #1; n_run++;
        if (ill !== 1'b0) begin n_fail++; $display("FAIL R10 fall actual=%b expected=0", ill); end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        t_reset; t_store; t_branch; t_upper; t_itype; t_op;
        t_system; t_gating; t_boundary; t_comb;
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule